// File: doc/BRIEF.md
# Converter Control Register and Successive-Approximation Sequencer

This block is the digital side of an on-chip successive-approximation converter. Software sees one 8-bit control register. Through it, software picks the reference source, the conversion clock rate and the input channel, powers the reference ladder, and starts a conversion. A conversion is requested by writing the run bit. The hardware then derives a step enable from the system clock, or from a separate slow ring-oscillator tick. It also latches the channel and resolves a 10-bit code, most significant bit first, against a comparator bit that the analog side returns.

When the last bit is decided, three things happen in the same cycle: the result register loads, a one-cycle done pulse is raised, and the run bit drops. Software cannot clear the run bit. The block also decides which function owns the pin that is shared between the external reference, the timer clock input and a general port bit.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset the register reads 0x00, `result` is 0, `donePulse` is 0, `ladderPowerOn` is 0 and `pinOwner` is 2'b00.
- R2: Register layout, bit 7 down to bit 0: reference-from-pin select, clock select high, clock select low, run, ladder enable, a bit that always reads 0, channel high, channel low. A write stores the writable fields, and reading returns them.
- R3: A write with bit 4 = 1 starts a conversion only if the same write also sets bit 3 = 1 and no conversion is running. Otherwise the run bit stays 0, no step enable appears and no done pulse follows.
- R4: While a conversion runs, a write with bit 4 = 0 does not clear the run bit. A further write with bit 4 = 1 neither restarts nor lengthens the conversion.
- R5: Clock select 00 divides the system clock by 16, 01 by 4 and 10 by 64. A conversion lasts 10 steps, so the done pulse arrives 10×divisor cycles after the cycle in which the run bit went to 1. It lasts one cycle, and in that cycle the run bit already reads 0.
- R6: Each step keeps the trial bit when `cmpIn` = 1 (input at or above `sarCode`) and drops it otherwise, starting at bit 9. `result` is the 10-bit code that this search produces.
- R7: `chanSel` takes the channel field written with the start request and holds it until the next start, whatever is written in between.
- R8: The clock select in force is captured at start. A new value written during a conversion applies from the next start.
- R9: `pinOwner` is 2'b10 (reference) when bit 7 = 1 and `timerSrcSel` = 0, 2'b01 (timer) when `timerSrcSel` = 1, and 2'b00 (port) otherwise. `refFromPin` is 1 exactly when the reference owns the pin.
- R10: `ladderPowerOn` follows register bit 3.
- R11: `convClkEn` pulses exactly 10 times per conversion and only while the run bit is 1. With clock select 11, the pulses come from `rcTick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| rcTick | input | 1 | Ring-oscillator tick, one system-clock-wide pulse, already synchronized |
| timerSrcSel | input | 1 | Timer takes its clock from the shared pin |
| cmpIn | input | 1 | Comparator result: 1 when the input is at or above the trial code |
| sarCode | output | 10 | Trial code driven to the resistor ladder |
| chanSel | output | 2 | Channel latched at start |
| convClkEn | output | 1 | Conversion step enable |
| ladderPowerOn | output | 1 | Reference ladder power enable |
| refFromPin | output | 1 | Reference taken from the shared pin instead of the supply |
| pinOwner | output | 2 | Owner of the shared pin (10 reference, 01 timer, 00 port) |
| result | output | 10 | Last completed conversion code |
| donePulse | output | 1 | One-cycle conversion-complete pulse |

## Verification
The assertions take for granted two things about the inputs. First, `cmpIn` is valid and settled at every step edge. Second, `rcTick` is a single-cycle pulse in the system clock domain. The bench meets both: it models the comparator as a combinational compare of a fixed analog level against `sarCode`, and it raises `rcTick` on every third cycle. All register writes and the `timerSrcSel` changes are driven on the falling edge, so every value is stable by the next rising edge.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef struct packed {
    logic start;
    logic step;
    logic last;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    PIN_PORT  = 2'b00,
    PIN_TIMER = 2'b01,
    PIN_REF   = 2'b10
  } pinOwner_e;

  localparam int REG_W = 8;
endpackage

// File: rtl/adc_ctrl_fsm.sv
module adc_ctrl_fsm
  import adc_ctrl_pkg::*;
#(
  parameter int DIV_SEL0 = 16,
  parameter int DIV_SEL1 = 4,
  parameter int DIV_SEL2 = 64,
  parameter int STEPS    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             rcTick,
  input  logic             timerSrcSel,
  output seqStrobe_t       strobe,
  output logic             convClkEn,
  output logic             ladderPowerOn,
  output logic             refFromPin,
  output logic [1:0]       pinOwner
);
  localparam int DIV_MAX01 = (DIV_SEL0 > DIV_SEL1) ? DIV_SEL0 : DIV_SEL1;
  localparam int DIV_MAX   = (DIV_MAX01 > DIV_SEL2) ? DIV_MAX01 : DIV_SEL2;
  localparam int CNT_W     = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam int STEP_W    = (STEPS > 2) ? $clog2(STEPS) : 1;

  logic             vrefSel;
  logic [1:0]       ckrSel;
  logic [1:0]       ckrHeld;
  logic             runFlag;
  logic             pdEn;
  logic [1:0]       chanReg;
  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] divLim;
  logic [STEP_W-1:0] stepLeft;
  logic             startReq;
  logic             tickRaw;
  logic             tick;
  logic             lastStep;
  logic             unusedWrBit;

  assign unusedWrBit = regWrData[2];

  assign startReq = regWrEn && regWrData[4] && regWrData[3] && !runFlag;

  always_comb begin
    case (ckrHeld)
      2'b01:   divLim = CNT_W'(DIV_SEL1 - 1);
      2'b10:   divLim = CNT_W'(DIV_SEL2 - 1);
      default: divLim = CNT_W'(DIV_SEL0 - 1);
    endcase
  end

  assign tickRaw  = (ckrHeld == 2'b11) ? rcTick : (preCnt == divLim);
  assign tick     = runFlag && tickRaw;
  assign lastStep = tick && (stepLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vrefSel  <= 1'b0;
      ckrSel   <= 2'b00;
      ckrHeld  <= 2'b00;
      runFlag  <= 1'b0;
      pdEn     <= 1'b0;
      chanReg  <= 2'b00;
      preCnt   <= '0;
      stepLeft <= '0;
    end else begin
      if (regWrEn) begin
        vrefSel <= regWrData[7];
        ckrSel  <= regWrData[6:5];
        pdEn    <= regWrData[3];
        chanReg <= regWrData[1:0];
      end
      if (startReq) begin
        runFlag  <= 1'b1;
        ckrHeld  <= regWrData[6:5];
        preCnt   <= '0;
        stepLeft <= STEP_W'(STEPS - 1);
      end else if (runFlag) begin
        if (ckrHeld != 2'b11) begin
          preCnt <= (preCnt == divLim) ? '0 : preCnt + 1'b1;
        end
        if (tick) begin
          stepLeft <= stepLeft - 1'b1;
        end
        if (lastStep) begin
          runFlag <= 1'b0;
        end
      end
    end
  end

  assign strobe.start = startReq;
  assign strobe.step  = tick;
  assign strobe.last  = lastStep;
  assign convClkEn    = tick;
  assign ladderPowerOn = pdEn;
  assign regRdData    = {vrefSel, ckrSel, runFlag, pdEn, 1'b0, chanReg};

  always_comb begin
    if (vrefSel && !timerSrcSel) begin
      pinOwner = PIN_REF;
    end else if (timerSrcSel) begin
      pinOwner = PIN_TIMER;
    end else begin
      pinOwner = PIN_PORT;
    end
  end
  assign refFromPin = (pinOwner == PIN_REF);

  assert_start_needs_power_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runFlag) |-> pdEn);

  assert_run_not_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && !lastStep) |=> runFlag);

  assert_ckr_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && $past(runFlag)) |-> $stable(ckrHeld));
endmodule

// File: rtl/adc_ctrl_dp.sv
module adc_ctrl_dp
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cmpIn,
  input  logic [CHAN_W-1:0] chanIn,
  output logic [RES_W-1:0]  sarCode,
  output logic [RES_W-1:0]  result,
  output logic              donePulse,
  output logic [CHAN_W-1:0] chanHeld
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trialMask;
  logic [RES_W-1:0] sarReg;
  logic [RES_W-1:0] resolved;
  logic             busy;

  assign resolved = cmpIn ? sarReg : (sarReg & ~trialMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialMask <= '0;
      sarReg    <= '0;
      result    <= '0;
      donePulse <= 1'b0;
      chanHeld  <= '0;
      busy      <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      if (strobe.start) begin
        trialMask <= TOP_BIT;
        sarReg    <= TOP_BIT;
        chanHeld  <= chanIn;
        busy      <= 1'b1;
      end else if (strobe.step) begin
        if (strobe.last) begin
          sarReg    <= resolved;
          result    <= resolved;
          donePulse <= 1'b1;
          busy      <= 1'b0;
        end else begin
          trialMask <= trialMask >> 1;
          sarReg    <= resolved | (trialMask >> 1);
        end
      end
    end
  end

  assign sarCode = sarReg;

  assert_chan_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(chanHeld));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_result_on_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |-> $stable(result));
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int DIV_SEL0 = 16,
  parameter int DIV_SEL1 = 4,
  parameter int DIV_SEL2 = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             rcTick,
  input  logic             timerSrcSel,
  input  logic             cmpIn,
  output logic [RES_W-1:0] sarCode,
  output logic [1:0]       chanSel,
  output logic             convClkEn,
  output logic             ladderPowerOn,
  output logic             refFromPin,
  output logic [1:0]       pinOwner,
  output logic [RES_W-1:0] result,
  output logic             donePulse
);
  seqStrobe_t strobe;

  adc_ctrl_fsm #(
    .DIV_SEL0(DIV_SEL0),
    .DIV_SEL1(DIV_SEL1),
    .DIV_SEL2(DIV_SEL2),
    .STEPS   (RES_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .rcTick       (rcTick),
    .timerSrcSel  (timerSrcSel),
    .strobe       (strobe),
    .convClkEn    (convClkEn),
    .ladderPowerOn(ladderPowerOn),
    .refFromPin   (refFromPin),
    .pinOwner     (pinOwner)
  );

  adc_ctrl_dp #(
    .RES_W (RES_W),
    .CHAN_W(2)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmpIn    (cmpIn),
    .chanIn   (regWrData[1:0]),
    .sarCode  (sarCode),
    .result   (result),
    .donePulse(donePulse),
    .chanHeld (chanSel)
  );
endmodule

// File: tb/adc_ctrl_seq_tb.sv
`timescale 1ns/1ps
module adc_ctrl_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       rcTick;
  logic       timerSrcSel = 1'b0;
  logic       cmpIn;
  logic [9:0] sarCode;
  logic [1:0] chanSel;
  logic       convClkEn;
  logic       ladderPowerOn;
  logic       refFromPin;
  logic [1:0] pinOwner;
  logic [9:0] result;
  logic       donePulse;

  int cyc = 0;
  int vin = 0;
  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign rcTick = (cyc % 3 == 0);
  always_comb cmpIn = (int'(sarCode) <= vin);

  adc_ctrl_seq dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rcTick(rcTick), .timerSrcSel(timerSrcSel),
    .cmpIn(cmpIn), .sarCode(sarCode), .chanSel(chanSel), .convClkEn(convClkEn),
    .ladderPowerOn(ladderPowerOn), .refFromPin(refFromPin), .pinOwner(pinOwner),
    .result(result), .donePulse(donePulse)
  );

  // {ckr[1:0], chan[1:0], vin[9:0]}
  localparam logic [13:0] VEC [0:5] = '{
    {2'b00, 2'd1, 10'd300},
    {2'b01, 2'd2, 10'd1023},
    {2'b10, 2'd3, 10'd0},
    {2'b11, 2'd0, 10'd513},
    {2'b01, 2'd0, 10'd682},
    {2'b00, 2'd3, 10'd1}
  };

  function automatic int divOf(input logic [1:0] c);
    case (c)
      2'b01:   return 4;
      2'b10:   return 64;
      2'b11:   return 0;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitDone(output int doneCyc, output int pulses);
    pulses = 0;
    doneCyc = -1;
    for (int i = 0; i < 3000; i++) begin
      if (donePulse) begin
        doneCyc = cyc;
        break;
      end
      if (convClkEn) pulses++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    int n0, dc, pl, dv;
    logic [13:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(regRdData == 8'h00, "R1 reg", regRdData, 0);
    chk(result == 0 && donePulse == 0, "R1 result/done", result, 0);
    chk(ladderPowerOn == 0 && pinOwner == 2'b00, "R1 power/pin", pinOwner, 0);

    // R2 layout, bit 2 reads 0; R10 ladder power
    wr(8'h6F);
    chk(regRdData == 8'h6B, "R2 readback", regRdData, 8'h6B);
    chk(ladderPowerOn == 1'b1, "R10 ladder on", ladderPowerOn, 1);
    wr(8'h83);
    chk(regRdData == 8'h83, "R2 readback vref", regRdData, 8'h83);
    chk(ladderPowerOn == 1'b0, "R10 ladder off", ladderPowerOn, 0);

    // R9 pin ownership
    timerSrcSel = 1'b0; @(negedge clk);
    chk(pinOwner == 2'b10 && refFromPin, "R9 ref owns", pinOwner, 2);
    timerSrcSel = 1'b1; @(negedge clk);
    chk(pinOwner == 2'b01 && !refFromPin, "R9 timer beats ref", pinOwner, 1);
    wr(8'h03);
    chk(pinOwner == 2'b01, "R9 timer owns", pinOwner, 1);
    timerSrcSel = 1'b0; @(negedge clk);
    chk(pinOwner == 2'b00 && !refFromPin, "R9 port owns", pinOwner, 0);

    // R3 start ignored while ladder disabled
    wr(8'h10);
    chk(regRdData[4] == 1'b0, "R3 run stays 0", regRdData[4], 0);
    waitDone(dc, pl);
    chk(dc == -1, "R3 no done", dc, -1);
    chk(pl == 0, "R3 no step enable", pl, 0);

    // R5 R6 R7 R11 table of conversions
    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      vin = int'(v[9:0]);
      dv = divOf(v[13:12]);
      wr({1'b0, v[13:12], 1'b1, 1'b1, 1'b0, v[11:10]});
      n0 = cyc;
      chk(regRdData[4] == 1'b1, "R3 run set", regRdData[4], 1);
      waitDone(dc, pl);
      if (dv != 0) chk(dc - n0 == 10 * dv, "R5 duration", dc - n0, 10 * dv);
      chk(regRdData[4] == 1'b0, "R5 run clear at done", regRdData[4], 0);
      chk(pl == 10, "R11 step count", pl, 10);
      chk(int'(result) == vin, "R6 result", result, vin);
      chk(chanSel == v[11:10], "R7 channel", chanSel, v[11:10]);
      @(negedge clk);
      chk(donePulse == 1'b0, "R5 one-cycle done", donePulse, 0);
    end

    // R4 R7 R8 writes during a conversion
    vin = 77;
    wr(8'h38);
    n0 = cyc;
    repeat (4) @(negedge clk);
    wr(8'h49);
    chk(regRdData[4] == 1'b1, "R4 write 0 keeps run", regRdData[4], 1);
    chk(chanSel == 2'd0, "R7 channel held", chanSel, 0);
    repeat (4) @(negedge clk);
    wr(8'h59);
    waitDone(dc, pl);
    chk(dc - n0 == 40, "R8 old divisor kept, R4 no restart", dc - n0, 40);
    chk(int'(result) == 77, "R6 result mid-writes", result, 77);
    chk(chanSel == 2'd0, "R7 channel at done", chanSel, 0);
    chk(regRdData == 8'h49, "R2 fields after writes", regRdData, 8'h49);
    vin = 900;
    wr(8'h59);
    n0 = cyc;
    waitDone(dc, pl);
    chk(dc - n0 == 640, "R8 new divisor at next start", dc - n0, 640);
    chk(chanSel == 2'd1, "R7 new channel", chanSel, 1);
    chk(int'(result) == 900, "R6 result div64", result, 900);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule